// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation tree that sits in memory. A table root register holds the physical location of the top-level table. When a walk starts, the walker forms the address of the top-level entry and reads it over a single-outstanding request/response port. If that entry is usable, the walker follows it to a second-level table and reads the leaf entry. The leaf entry gives the physical page number, which is joined to the 12-bit page offset.

Each walk finishes with a one-cycle completion pulse, a physical address and a two-bit fault class. The fault classes let software tell three cases apart:
- an address that is not mapped at all, which is an error;
- a mapped page that is currently not in memory, which can be retried after it is brought in;
- an access that the protection flag forbids.

An unusable top-level entry ends the walk after a single read, because nothing behind it is mapped. The block is meant to sit between a lookup cache miss path and the memory system. It keeps one walk in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address splits into a top-level index (bits 31:22), a second-level index (bits 21:12) and a page offset (bits 11:0). The first read goes to root + top index × 4. The second read goes to (top entry bits 31:12 followed by twelve zero bits) + second index × 4.
- R2: Every table entry is 32 bits: bits 31:12 are a page number, bit 0 is the valid flag, bit 1 is the resident flag and bit 2 is the protected flag.
- R3: A leaf entry that is valid, resident and not protected gives fault code 0 and physical address {entry bits 31:12, offset}. Such a walk makes exactly two reads.
- R4: A top-level entry with bit 0 clear ends the walk with fault code 1 after exactly one read, and no second read is issued. The resident and protected bits of a top-level entry have no effect.
- R5: For a leaf entry, the fault codes are 1 for valid clear, 2 for resident clear and 3 for protected set, checked in that priority order. On any fault the physical address output is 0.
- R6: The root register is loaded by `root_wr`. Its value is captured when a walk is accepted, so a write during a walk changes only walks that start later.
- R7: `mem_req_valid` stays high with an unchanged `mem_req_addr` until `mem_req_ready` is seen. No new request is raised while a read is still awaiting its response.
- R8: A start is taken only while `busy` is low. `busy` rises on the cycle after acceptance and stays high through the completion cycle. A start while busy is ignored and causes no later walk.
- R9: `done` is high for exactly one cycle per walk. `result_paddr` and `result_fault` hold their values until the next walk produces a result.
- R10: After reset, `busy`, `done` and `mem_req_valid` are low, `result_fault` is 0 and `result_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_wr | input | 1 | Load the table root register |
| root_wdata | input | 32 | New physical address of the top-level table |
| walk_start | input | 1 | Request a translation (taken when not busy) |
| walk_vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle completion pulse |
| result_paddr | output | 32 | Translated physical address (0 on fault) |
| result_fault | output | 2 | 0 none, 1 unmapped, 2 not resident, 3 protected |

## Verification
The bound checker watches, on every cycle, the request-hold rule and the single-outstanding-read rule at the memory port. It also checks the one-cycle completion pulse, the holding of results while idle, the zero address on faults, the early stop after an unusable top-level entry, and the read count of successful walks. The exact entry addresses, the fault class chosen among conflicting leaf flags, the effect of a root rewrite during a walk and the dropping of a start while busy all depend on memory contents and stimulus timing. Only the bench's table-driven and directed scenarios can show those.

// File: rtl/ptw_pkg.sv
// Package: shared types and entry-flag positions for the translation walker.
// Assumes 32-bit entries with flags in the low bits and a page number above the offset.
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_DONE    = 3'd5
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_UNMAPPED = 2'd1,
        FLT_ABSENT   = 2'd2,
        FLT_PROT     = 2'd3
    } walk_fault_e;

    localparam int FLAG_VALID_BIT = 0;
    localparam int FLAG_RES_BIT   = 1;
    localparam int FLAG_PROT_BIT  = 2;

endpackage

// File: rtl/ptw_va_split.sv
// Module: splits a virtual address into top-level index, second-level index and page offset.
// Assumes VA_W == L1_IDX_W + L2_IDX_W + OFF_W; purely combinational.
module ptw_va_split #(
    parameter int VA_W     = 32,
    parameter int L1_IDX_W = 10,
    parameter int L2_IDX_W = 10,
    parameter int OFF_W    = 12
) (
    input  logic [VA_W-1:0]     vaddr,
    output logic [L1_IDX_W-1:0] l1_idx,
    output logic [L2_IDX_W-1:0] l2_idx,
    output logic [OFF_W-1:0]    offset
);
    localparam int L2_LSB = OFF_W;
    localparam int L1_LSB = OFF_W + L2_IDX_W;

    // Field extraction by fixed bit position.
    always_comb begin
        l1_idx = vaddr[L1_LSB +: L1_IDX_W];
        l2_idx = vaddr[L2_LSB +: L2_IDX_W];
        offset = vaddr[OFF_W-1:0];
    end
endmodule

// File: rtl/ptw_entry_addr.sv
// Module: forms the physical address of one table entry from a table base and an index.
// Assumes entries are 2**ENT_LOG2 bytes; carries past AW bits are dropped.
module ptw_entry_addr #(
    parameter int AW       = 32,
    parameter int IDX_W    = 10,
    parameter int ENT_LOG2 = 2
) (
    input  logic [AW-1:0]    table_base,
    input  logic [IDX_W-1:0] index,
    output logic [AW-1:0]    entry_addr
);
    logic [AW-1:0] scaled;

    // Scale the index by the entry size and add it to the base.
    always_comb begin
        scaled     = AW'(index) << ENT_LOG2;
        entry_addr = table_base + scaled;
    end
endmodule

// File: rtl/ptw_pte_check.sv
// Module: decodes one table entry into a page number and a fault class.
// Assumes the flag positions in ptw_pkg. LEAF=0 checks only the valid flag, as for a
// top-level pointer; LEAF=1 applies unmapped > absent > protected priority.
module ptw_pte_check
    import ptw_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int OFF_W = 12,
    parameter bit LEAF  = 1'b1
) (
    input  logic [PTE_W-1:0]       pte,
    output logic [PTE_W-OFF_W-1:0] ppn,
    output walk_fault_e            fault
);
    logic f_valid;
    logic f_res;
    logic f_prot;

    // Split the entry into flag bits and page number.
    always_comb begin
        f_valid = pte[FLAG_VALID_BIT];
        f_res   = pte[FLAG_RES_BIT];
        f_prot  = pte[FLAG_PROT_BIT];
        ppn     = pte[PTE_W-1:OFF_W];
    end

    generate
        if (LEAF) begin : g_leaf
            // Leaf classification in fixed priority order.
            always_comb begin
                if (!f_valid)     fault = FLT_UNMAPPED;
                else if (!f_res)  fault = FLT_ABSENT;
                else if (f_prot)  fault = FLT_PROT;
                else              fault = FLT_NONE;
            end
        end else begin : g_dir
            // Pointer entry: only the valid flag matters.
            always_comb begin
                fault = f_valid ? FLT_NONE : FLT_UNMAPPED;
            end
        end
    endgenerate
endmodule

// File: rtl/ptw_walk_fsm.sv
// Module: sequencing of one walk through request, wait and completion states.
// Assumes one read in flight; the responder returns exactly one response per accepted request.
module ptw_walk_fsm
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        req_ready,
    input  logic        resp_valid,
    input  logic        l1_ok,
    output walk_state_e state,
    output logic        accept
);
    walk_state_e state_d;

    // Walk is accepted only from idle.
    always_comb accept = (state == ST_IDLE) && start;

    // Next-state selection.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (start)      state_d = ST_L1_REQ;
            ST_L1_REQ:  if (req_ready)  state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (resp_valid) state_d = l1_ok ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  if (req_ready)  state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (resp_valid) state_d = ST_DONE;
            ST_DONE:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end
endmodule

// File: rtl/ptw_walker.sv
// Module: top of the two-level translation walker.
// Assumes memory answers each accepted read once; the root register is captured per walk.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PA_W     = 32,
    parameter int PTE_W    = 32,
    parameter int OFF_W    = 12,
    parameter int L1_IDX_W = 10,
    parameter int L2_IDX_W = 10,
    parameter int ENT_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             root_wr,
    input  logic [PA_W-1:0]  root_wdata,
    input  logic             walk_start,
    input  logic [VA_W-1:0]  walk_vaddr,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_resp_valid,
    input  logic [PTE_W-1:0] mem_resp_data,
    output logic             done,
    output logic [PA_W-1:0]  result_paddr,
    output logic [1:0]       result_fault
);
    localparam int PPN_W   = PTE_W - OFF_W;
    localparam int LEVELS  = 2;
    localparam int IDX_MAX = (L1_IDX_W > L2_IDX_W) ? L1_IDX_W : L2_IDX_W;

    walk_state_e       state;
    logic              accept;
    logic [PA_W-1:0]   root_q;
    logic [PA_W-1:0]   walk_root_q;
    logic [PA_W-1:0]   l2_table_q;
    logic [VA_W-1:0]   va_q;
    logic [L1_IDX_W-1:0] l1_idx;
    logic [L2_IDX_W-1:0] l2_idx;
    logic [OFF_W-1:0]  offset;
    logic [PPN_W-1:0]  dir_ppn;
    logic [PPN_W-1:0]  leaf_ppn;
    walk_fault_e       dir_fault;
    walk_fault_e       leaf_fault;
    logic              l1_ok;
    logic [PA_W-1:0]   paddr_q;
    walk_fault_e       fault_q;

    logic [PA_W-1:0]    lvl_base [LEVELS];
    logic [IDX_MAX-1:0] lvl_idx  [LEVELS];
    logic [PA_W-1:0]    lvl_addr [LEVELS];

    // Address field extraction from the captured virtual address.
    ptw_va_split #(
        .VA_W(VA_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W), .OFF_W(OFF_W)
    ) u_split (
        .vaddr(va_q), .l1_idx(l1_idx), .l2_idx(l2_idx), .offset(offset)
    );

    // Per-level base and index selection feeding the address adders.
    always_comb begin
        lvl_base[0] = walk_root_q;
        lvl_base[1] = l2_table_q;
        lvl_idx[0]  = IDX_MAX'(l1_idx);
        lvl_idx[1]  = IDX_MAX'(l2_idx);
    end

    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_lvl
            ptw_entry_addr #(
                .AW(PA_W), .IDX_W(IDX_MAX), .ENT_LOG2(ENT_LOG2)
            ) u_eaddr (
                .table_base(lvl_base[g]),
                .index(lvl_idx[g]),
                .entry_addr(lvl_addr[g])
            );
        end
    endgenerate

    // Entry decode for the pointer level and the leaf level.
    ptw_pte_check #(.PTE_W(PTE_W), .OFF_W(OFF_W), .LEAF(1'b0)) u_dir_chk (
        .pte(mem_resp_data), .ppn(dir_ppn), .fault(dir_fault)
    );
    ptw_pte_check #(.PTE_W(PTE_W), .OFF_W(OFF_W), .LEAF(1'b1)) u_leaf_chk (
        .pte(mem_resp_data), .ppn(leaf_ppn), .fault(leaf_fault)
    );

    always_comb l1_ok = (dir_fault == FLT_NONE);

    // Walk sequencing.
    ptw_walk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(walk_start),
        .req_ready(mem_req_ready), .resp_valid(mem_resp_valid),
        .l1_ok(l1_ok), .state(state), .accept(accept)
    );

    // Table root register, written by software at address-space changes.
    always_ff @(posedge clk) begin
        if (!rst_n)       root_q <= '0;
        else if (root_wr) root_q <= root_wdata;
    end

    // Per-walk capture of the virtual address and root.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            walk_root_q <= '0;
        end else if (accept) begin
            va_q        <= walk_vaddr;
            walk_root_q <= root_q;
        end
    end

    // Second-level table base taken from a usable pointer entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l2_table_q <= '0;
        end else if (state == ST_L1_WAIT && mem_resp_valid && l1_ok) begin
            l2_table_q <= PA_W'({dir_ppn, {OFF_W{1'b0}}});
        end
    end

    // Result registers, updated only when a walk resolves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else if (state == ST_L1_WAIT && mem_resp_valid && !l1_ok) begin
            paddr_q <= '0;
            fault_q <= FLT_UNMAPPED;
        end else if (state == ST_L2_WAIT && mem_resp_valid) begin
            fault_q <= leaf_fault;
            paddr_q <= (leaf_fault == FLT_NONE) ? PA_W'({leaf_ppn, offset}) : '0;
        end
    end

    // Output decode from state and result registers.
    always_comb begin
        busy          = (state != ST_IDLE);
        done          = (state == ST_DONE);
        mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
        mem_req_addr  = (state == ST_L2_REQ) ? lvl_addr[1] : lvl_addr[0];
        result_paddr  = paddr_q;
        result_fault  = fault_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Module: protocol and result checker bound to ptw_walker; observes ports only.
// Assumes the synchronous active-low reset of the walker.
module ptw_walker_chk #(
    parameter int PA_W  = 32,
    parameter int PTE_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             walk_start,
    input logic             busy,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_resp_valid,
    input logic [PTE_W-1:0] mem_resp_data,
    input logic             done,
    input logic [PA_W-1:0]  result_paddr,
    input logic [1:0]       result_fault
);
    logic       pend_q;
    logic [1:0] rd_cnt_q;
    logic       dir_bad_q;

    // Tracks an accepted read still awaiting its response.
    always_ff @(posedge clk) begin
        if (!rst_n)                               pend_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready)  pend_q <= 1'b1;
        else if (mem_resp_valid)                  pend_q <= 1'b0;
    end

    // Counts reads per walk and notes an unusable pointer entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt_q  <= '0;
            dir_bad_q <= 1'b0;
        end else if (walk_start && !busy) begin
            rd_cnt_q  <= '0;
            dir_bad_q <= 1'b0;
        end else begin
            if (mem_req_valid && mem_req_ready) rd_cnt_q <= rd_cnt_q + 2'd1;
            if (mem_resp_valid && rd_cnt_q == 2'd1 && !mem_resp_data[0]) dir_bad_q <= 1'b1;
        end
    end

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !mem_req_valid);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result_paddr) && $stable(result_fault));

    assert_busy_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start && !busy |=> busy && !done);

    assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done && result_fault != 2'd0 |-> result_paddr == '0);

    assert_early_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dir_bad_q |-> !mem_req_valid);

    assert_two_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done && result_fault == 2'd0 |-> rd_cnt_q == 2'd2);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W), .PTE_W(PTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data), .done(done),
    .result_paddr(result_paddr), .result_fault(result_fault)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_wr = 1'b0;
    logic [31:0] root_wdata = '0;
    logic        walk_start = 1'b0;
    logic [31:0] walk_vaddr = '0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;
    logic        done;
    logic [31:0] result_paddr;
    logic [1:0]  result_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    ptw_walker u_dut (
        .clk(clk), .rst_n(rst_n), .root_wr(root_wr), .root_wdata(root_wdata),
        .walk_start(walk_start), .walk_vaddr(walk_vaddr), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
        .mem_resp_data(mem_resp_data), .done(done),
        .result_paddr(result_paddr), .result_fault(result_fault)
    );

    // Memory model: sparse word store, configurable stall and latency.
    logic [31:0] mem [logic [31:0]];
    logic        ready_en = 1'b1;
    int          lat = 0;
    int          rd_total = 0;
    logic [31:0] rd_log [0:63];
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          pend_cnt = 0;

    assign mem_req_ready = ready_en;

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_resp_valid <= 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_resp_valid <= 1'b1;
                mem_resp_data  <= peek(pend_addr);
                pend           <= 1'b0;
            end else begin
                pend_cnt <= pend_cnt - 1;
            end
        end
        if (mem_req_valid && mem_req_ready) begin
            pend      <= 1'b1;
            pend_addr <= mem_req_addr;
            pend_cnt  <= lat;
            rd_log[rd_total[5:0]] <= mem_req_addr;
            rd_total  <= rd_total + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic write_root(input logic [31:0] v);
        @(negedge clk);
        root_wr = 1'b1; root_wdata = v;
        @(negedge clk);
        root_wr = 1'b0;
    endtask

    task automatic launch(input logic [31:0] va);
        @(negedge clk);
        walk_start = 1'b1; walk_vaddr = va;
        @(negedge clk);
        walk_start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  fault;
        logic [31:0] paddr;
        logic [1:0]  reads;
        logic [31:0] l2_addr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_0123, 2'd0, 32'h0010_5123, 2'd2, 32'h0000_2000}, // R3 success
        '{32'h0040_1456, 2'd2, 32'h0000_0000, 2'd2, 32'h0000_2004}, // R5 not resident
        '{32'h0040_2007, 2'd3, 32'h0000_0000, 2'd2, 32'h0000_2008}, // R5 protected
        '{32'h0040_3000, 2'd1, 32'h0000_0000, 2'd2, 32'h0000_200C}, // R5 leaf unmapped
        '{32'h0040_4000, 2'd1, 32'h0000_0000, 2'd2, 32'h0000_2010}, // R5 unmapped beats others
        '{32'h0040_5800, 2'd2, 32'h0000_0000, 2'd2, 32'h0000_2014}, // R5 absent beats protected
        '{32'h0080_0010, 2'd1, 32'h0000_0000, 2'd1, 32'h0000_0000}, // R4 early stop
        '{32'hFFFF_FFFF, 2'd0, 32'hABCD_EFFF, 2'd2, 32'h0000_3FFC}  // R4 flags ignored, R1 top index
    };

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        bit seen;
        int base_rd;
        logic [31:0] root;

        // Table contents (R2 entry layout).
        mem[32'h0000_1004] = 32'h0000_2001;
        mem[32'h0000_1FFC] = 32'h0000_3005;
        mem[32'h0000_2000] = 32'h0010_5003;
        mem[32'h0000_2004] = 32'h0000_F001;
        mem[32'h0000_2008] = 32'h0028_3007;
        mem[32'h0000_2010] = 32'h1234_5006;
        mem[32'h0000_2014] = 32'h0045_6005;
        mem[32'h0000_3FFC] = 32'hABCD_E003;
        mem[32'h0000_5004] = 32'h0000_6001;
        mem[32'h0000_6000] = 32'h0077_7003;

        repeat (3) @(negedge clk);
        // R10 reset state
        check(!busy, "R10", "busy", 32'(busy), 32'h0);
        check(!done, "R10", "done", 32'(done), 32'h0);
        check(!mem_req_valid, "R10", "req_valid", 32'(mem_req_valid), 32'h0);
        check(result_fault == 2'd0, "R10", "fault", 32'(result_fault), 32'h0);
        check(result_paddr == 32'h0, "R10", "paddr", result_paddr, 32'h0);
        rst_n = 1'b1;

        root = 32'h0000_1000;
        write_root(root);

        // Table-driven vectors.
        for (int v = 0; v < NV; v++) begin
            base_rd = rd_total;
            launch(VECS[v].va);
            wait_done(seen);
            check(seen, "R3", "walk completes", 32'(seen), 32'h1);
            check(result_fault == VECS[v].fault, "R5", "fault code", 32'(result_fault), 32'(VECS[v].fault));
            check(result_paddr == VECS[v].paddr, "R3", "paddr", result_paddr, VECS[v].paddr);
            check(rd_total - base_rd == int'(VECS[v].reads), "R4", "read count",
                  32'(rd_total - base_rd), 32'(VECS[v].reads));
            check(rd_log[base_rd[5:0]] == root + {20'h0, VECS[v].va[31:22], 2'b00}, "R1",
                  "first entry addr", rd_log[base_rd[5:0]], root + {20'h0, VECS[v].va[31:22], 2'b00});
            if (VECS[v].reads == 2'd2)
                check(rd_log[(base_rd + 1) % 64] == VECS[v].l2_addr, "R1", "second entry addr",
                      rd_log[(base_rd + 1) % 64], VECS[v].l2_addr);
            @(negedge clk);
            check(!done, "R9", "done one cycle", 32'(done), 32'h0);
        end

        // R9: results held while idle.
        repeat (4) @(negedge clk);
        check(result_paddr == 32'hABCD_EFFF, "R9", "held paddr", result_paddr, 32'hABCD_EFFF);

        // R7: stalled request holds address, no read issued.
        ready_en = 1'b0;
        base_rd = rd_total;
        launch(32'h0040_0123);
        check(busy, "R8", "busy after accept", 32'(busy), 32'h1);
        repeat (5) @(negedge clk);
        check(mem_req_valid && mem_req_addr == 32'h0000_1004, "R7", "held request",
              mem_req_addr, 32'h0000_1004);
        check(rd_total == base_rd, "R7", "no read while stalled", 32'(rd_total - base_rd), 32'h0);
        ready_en = 1'b1;
        lat = 3;
        wait_done(seen);
        check(result_paddr == 32'h0010_5123, "R7", "paddr after stall+latency", result_paddr, 32'h0010_5123);
        lat = 0;

        // R8: start while busy is ignored.
        @(negedge clk);
        base_rd = rd_total;
        launch(32'h0040_0123);
        @(negedge clk);
        walk_start = 1'b1; walk_vaddr = 32'h0040_1456;
        @(negedge clk);
        walk_start = 1'b0;
        wait_done(seen);
        check(result_fault == 2'd0 && result_paddr == 32'h0010_5123, "R8", "first walk result",
              result_paddr, 32'h0010_5123);
        repeat (6) @(negedge clk);
        check(!busy && rd_total - base_rd == 2, "R8", "no extra walk", 32'(rd_total - base_rd), 32'h2);

        // R6: root rewrite, and a rewrite during a walk.
        write_root(32'h0000_5000);
        base_rd = rd_total;
        launch(32'h0040_0ABC);
        root_wr = 1'b1; root_wdata = 32'h0000_1000;
        @(negedge clk);
        root_wr = 1'b0;
        wait_done(seen);
        check(rd_log[base_rd[5:0]] == 32'h0000_5004, "R6", "captured root", rd_log[base_rd[5:0]], 32'h0000_5004);
        check(result_paddr == 32'h0077_7ABC, "R6", "paddr via new root", result_paddr, 32'h0077_7ABC);
        @(negedge clk);
        base_rd = rd_total;
        launch(32'h0040_0ABC);
        wait_done(seen);
        check(rd_log[base_rd[5:0]] == 32'h0000_1004, "R6", "later walk root", rd_log[base_rd[5:0]], 32'h0000_1004);
        check(result_paddr == 32'h0010_5ABC, "R6", "later walk paddr", result_paddr, 32'h0010_5ABC);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule